// File: doc/BRIEF.md
# Twelve-Channel Grayscale PWM Timing Controller

This block turns a latched configuration word into twelve on/off pulse-width-modulated channel outputs. The channels form four groups of red, green and blue. Each channel has its own 16-bit grayscale value. A shared grayscale counter advances once per selected edge of a chosen reference clock, and a channel is on while the counter is below that channel's value. Three 7-bit brightness fields in the same word, one for each colour group, are passed straight out as registered values for an analog stage outside this block.

Five control bits in the word govern the timing:
- blank forces every output off and holds the counter at zero;
- auto-repeat makes the counter wrap instead of stopping after one period;
- restart-on-latch lets a latch pulse restart the timing;
- clock select picks the internal oscillator input or the serial clock input;
- edge select picks the rising or the falling reference edge.

The word is captured into a shadow register only on a latch pulse, so the counter never acts on a partly written value. Both reference clocks are brought into the fast system clock domain through two-flop synchronisers. A one-cycle count enable is then derived from the selected edge.

Top module: `gs_pwm_ctrl`

## Requirements
- R1: After reset, all channel outputs are 0, all brightness outputs are 0 and blank is active, so toggling either reference clock leaves every output off until a word is latched.
- R2: The configuration word is loaded only on `latch_i`; a changing `cfg_word_i` without a latch has no effect. Field positions (GS_W bits per grayscale value, here GS_W=16): channel c (c = 3*group + colour, colour order red, green, blue) uses bits [c*GS_W +: GS_W]. The red, green and blue brightness fields start at bits 12*GS_W, 12*GS_W+7 and 12*GS_W+14. The control bits start at F = 12*GS_W+21: blank at F, auto-repeat at F+1, restart-on-latch at F+2, clock select at F+3 and edge select at F+4.
- R3: On each count tick, a channel output becomes 1 if the counter value before that tick is below the channel's grayscale value, and 0 otherwise. A value of 0 never turns the output on. The maximum value keeps it on for all but one tick of the period.
- R4: While blank is 1, all outputs are 0 and the counter stays at 0. After blank is released, counting starts from 0.
- R5: With auto-repeat set to 1, the counter wraps from its maximum to 0, so the output pattern repeats every 2^GS_W ticks.
- R6: With auto-repeat set to 0, the counter runs one period and then stops. All outputs stay 0 until blank is released again or a restarting latch occurs.
- R7: A latch pulse whose incoming word has restart-on-latch set to 1 sets the counter to 0 and forces all outputs to 0 on the next cycle. A latch pulse with that bit at 0 leaves the counter and the outputs unchanged.
- R8: Clock select set to 1 makes the serial clock input drive counting, and set to 0 makes the oscillator input drive it. The unselected input has no effect.
- R9: Edge select set to 1 counts on rising reference edges, and set to 0 counts on falling edges. Edges of the other polarity change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_clk_i | input | 1 | Internal oscillator reference clock |
| ser_clk_i | input | 1 | Serial reference clock |
| latch_i | input | 1 | One-cycle pulse that loads the configuration word |
| cfg_word_i | input | 12*GS_W+26 | Configuration word (grayscale, brightness, control) |
| chan_on_o | output | 12 | Channel on/off outputs, channel 0 in bit 0 |
| bright_red_o | output | 7 | Registered red-group brightness |
| bright_grn_o | output | 7 | Registered green-group brightness |
| bright_blu_o | output | 7 | Registered blue-group brightness |

## Verification
The channel values in the bench are spread over the whole range, so one run shows an always-off channel, a channel that is on for all but one tick, and every width in between. A wrong compare direction or an off-by-one limit therefore shows up in a specific channel. The same values are run with repeat and with one-shot counting: the second period separates wrapping from stopping. They are also run on each reference clock and on each edge polarity, while the other clock and the other edge are toggled, to confirm that those inputs are ignored. A latch in the middle of a period, first without and then with restart-on-latch, shows whether the count continues or restarts from zero. A blank phase followed by release confirms that counting restarts from zero.

// File: rtl/gs_pwm_pkg.sv
package gs_pwm_pkg;
    // Control field, LSB first: blank, repeat, restart, ext clock, rising edge
    typedef struct packed {
        logic edge_rise;
        logic ext_sel;
        logic restart_on_latch;
        logic auto_repeat;
        logic blank;
    } fc_t;

    localparam int FC_W      = 5;
    localparam int NUM_SRC   = 2;   // reference clock sources
    localparam int SRC_OSC   = 0;
    localparam int SRC_SER   = 1;
endpackage

// File: rtl/gs_refclk_tick.sv
module gs_refclk_tick
    import gs_pwm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_clk_i,
    input  logic ser_clk_i,
    input  logic sel_ext,
    input  logic edge_rise,
    output logic tick_o
);
    localparam int PIPE_W = SYNC_STAGES + 1;

    typedef struct packed {
        logic [NUM_SRC-1:0][PIPE_W-1:0] pipe;
    } st_t;

    st_t st_d, st_q;
    logic [NUM_SRC-1:0] raw;
    logic [NUM_SRC-1:0] rise_ev;
    logic [NUM_SRC-1:0] fall_ev;

    assign raw[SRC_OSC] = osc_clk_i;
    assign raw[SRC_SER] = ser_clk_i;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        assign rise_ev[s] =  st_q.pipe[s][SYNC_STAGES-1] & ~st_q.pipe[s][SYNC_STAGES];
        assign fall_ev[s] = ~st_q.pipe[s][SYNC_STAGES-1] &  st_q.pipe[s][SYNC_STAGES];
    end

    always_comb begin
        st_d = st_q;
        for (int s = 0; s < NUM_SRC; s++) begin
            st_d.pipe[s] = {st_q.pipe[s][PIPE_W-2:0], raw[s]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        if (sel_ext) tick_o = edge_rise ? rise_ev[SRC_SER] : fall_ev[SRC_SER];
        else         tick_o = edge_rise ? rise_ev[SRC_OSC] : fall_ev[SRC_OSC];
    end
endmodule

// File: rtl/gs_counter.sv
module gs_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             blank,
    input  logic             restart,
    input  logic             auto_repeat,
    output logic [CNT_W-1:0] cnt_o,
    output logic             done_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             done;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (blank || restart) begin
            st_d.cnt  = '0;
            st_d.done = 1'b0;
        end else if (tick && !st_q.done) begin
            if (st_q.cnt == CNT_MAX) begin
                if (auto_repeat) st_d.cnt  = '0;
                else             st_d.done = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o  = st_q.cnt;
    assign done_o = st_q.done;

    AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !blank && !restart) |=> $stable(cnt_o)); // R5

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !blank && !restart && !done_o && cnt_o != CNT_MAX)
        |=> (cnt_o == $past(cnt_o) + 1'b1)); // R5

    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !blank && !restart && auto_repeat && cnt_o == CNT_MAX)
        |=> (cnt_o == '0 && !done_o)); // R5
endmodule

// File: rtl/gs_chan_out.sv
module gs_chan_out #(
    parameter int NUM_CH = 12,
    parameter int CNT_W  = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          tick,
    input  logic                          clear,
    input  logic                          done,
    input  logic [CNT_W-1:0]              cnt,
    input  logic [NUM_CH-1:0][CNT_W-1:0]  gs_vals,
    output logic [NUM_CH-1:0]             on_o
);
    typedef struct packed {
        logic [NUM_CH-1:0] on;
    } st_t;

    st_t st_d, st_q;
    logic [NUM_CH-1:0] below;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_cmp
        assign below[c] = (cnt < gs_vals[c]);
    end

    always_comb begin
        st_d = st_q;
        if (clear)     st_d.on = '0;
        else if (tick) st_d.on = done ? '0 : below;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign on_o = st_q.on;

    AST_CLEAR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (on_o == '0)); // R4
endmodule

// File: rtl/gs_pwm_ctrl.sv
module gs_pwm_ctrl
    import gs_pwm_pkg::*;
#(
    parameter int NUM_GROUPS  = 4,
    parameter int GS_W        = 16,
    parameter int BC_W        = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     osc_clk_i,
    input  logic                                     ser_clk_i,
    input  logic                                     latch_i,
    input  logic [3*NUM_GROUPS*GS_W+3*BC_W+FC_W-1:0] cfg_word_i,
    output logic [3*NUM_GROUPS-1:0]                  chan_on_o,
    output logic [BC_W-1:0]                          bright_red_o,
    output logic [BC_W-1:0]                          bright_grn_o,
    output logic [BC_W-1:0]                          bright_blu_o
);
    localparam int NUM_CH  = 3 * NUM_GROUPS;
    localparam int GS_TOT  = NUM_CH * GS_W;
    localparam int BCR_LSB = GS_TOT;
    localparam int BCG_LSB = GS_TOT + BC_W;
    localparam int BCB_LSB = GS_TOT + 2 * BC_W;
    localparam int FC_LSB  = GS_TOT + 3 * BC_W;
    localparam int WORD_W  = FC_LSB + FC_W;
    localparam int RST_BIT = FC_LSB + 2;
    localparam logic [WORD_W-1:0] RESET_WORD = WORD_W'(1) << FC_LSB;

    typedef struct packed {
        logic [WORD_W-1:0] word;
    } sh_t;

    sh_t sh_d, sh_q;
    fc_t fc;
    logic [NUM_CH-1:0][GS_W-1:0] gs_vals;
    logic tick, restart, clear;
    logic [GS_W-1:0] cnt;
    logic cnt_done;

    always_comb begin
        sh_d = sh_q;
        if (latch_i) sh_d.word = cfg_word_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '{word: RESET_WORD};
        else        sh_q <= sh_d;
    end

    assign fc           = fc_t'(sh_q.word[FC_LSB +: FC_W]);
    assign gs_vals      = sh_q.word[GS_TOT-1:0];
    assign bright_red_o = sh_q.word[BCR_LSB +: BC_W];
    assign bright_grn_o = sh_q.word[BCG_LSB +: BC_W];
    assign bright_blu_o = sh_q.word[BCB_LSB +: BC_W];

    assign restart = latch_i & cfg_word_i[RST_BIT];
    assign clear   = fc.blank | restart;

    gs_refclk_tick #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .osc_clk_i (osc_clk_i),
        .ser_clk_i (ser_clk_i),
        .sel_ext   (fc.ext_sel),
        .edge_rise (fc.edge_rise),
        .tick_o    (tick)
    );

    gs_counter #(.CNT_W(GS_W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .blank       (fc.blank),
        .restart     (restart),
        .auto_repeat (fc.auto_repeat),
        .cnt_o       (cnt),
        .done_o      (cnt_done)
    );

    gs_chan_out #(.NUM_CH(NUM_CH), .CNT_W(GS_W)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .clear   (clear),
        .done    (cnt_done),
        .cnt     (cnt),
        .gs_vals (gs_vals),
        .on_o    (chan_on_o)
    );

    AST_BLANK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        fc.blank |=> (chan_on_o == '0 && cnt == '0)); // R4

    AST_RESTART_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_i && cfg_word_i[RST_BIT]) |=> (chan_on_o == '0 && cnt == '0)); // R7

    AST_DONE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_done |-> (chan_on_o == '0)); // R6
endmodule

// File: tb/tb_gs_pwm_ctrl.sv
`timescale 1ns/1ps
module tb_gs_pwm_ctrl;
    localparam int NG     = 4;
    localparam int NCH    = 3 * NG;
    localparam int GSW    = 4;
    localparam int BCW    = 7;
    localparam int FCL    = NCH * GSW + 3 * BCW;
    localparam int WW     = FCL + 5;
    localparam int MAXV   = (1 << GSW) - 1;
    localparam int HALF   = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic osc = 1'b0, ser = 1'b0, latch = 1'b0;
    logic [WW-1:0] word = '0;
    logic [NCH-1:0] chan;
    logic [BCW-1:0] br_r, br_g, br_b;

    always #2 clk = ~clk;

    gs_pwm_ctrl #(.NUM_GROUPS(NG), .GS_W(GSW), .BC_W(BCW)) dut (
        .clk(clk), .rst_n(rst_n), .osc_clk_i(osc), .ser_clk_i(ser),
        .latch_i(latch), .cfg_word_i(word), .chan_on_o(chan),
        .bright_red_o(br_r), .bright_grn_o(br_g), .bright_blu_o(br_b)
    );

    typedef struct {
        logic [NCH-1:0] exp;
        string          tag;
    } item_t;

    item_t q[$];
    event chk_ev;
    int n_tests = 0, n_fail = 0;

    // bench model state
    int m_gs[NCH];
    int m_cnt = 0;
    bit m_done = 0, m_blank = 1, m_rpt = 0, m_ext = 0, m_rise = 0;
    logic [NCH-1:0] m_out = '0;

    function automatic int gs_of(int sel, int c);
        if (sel == 0) return (c == NCH - 1) ? MAXV : c;
        return MAXV - c;
    endfunction

    function automatic logic [WW-1:0] mk_word(int sel, int r, int g, int b,
        bit blank, bit rpt, bit rst, bit ext, bit rise);
        logic [WW-1:0] w = '0;
        for (int c = 0; c < NCH; c++) w[c*GSW +: GSW] = GSW'(gs_of(sel, c));
        w[NCH*GSW +: BCW]         = BCW'(r);
        w[NCH*GSW + BCW +: BCW]   = BCW'(g);
        w[NCH*GSW + 2*BCW +: BCW] = BCW'(b);
        w[FCL]   = blank;
        w[FCL+1] = rpt;
        w[FCL+2] = rst;
        w[FCL+3] = ext;
        w[FCL+4] = rise;
        return w;
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push(string tag);
        item_t it;
        @(negedge clk);
        it.exp = m_out;
        it.tag = tag;
        q.push_back(it);
        ->chk_ev;
    endtask

    // monitor
    initial begin
        item_t it;
        forever begin
            @(chk_ev);
            while (q.size() > 0) begin
                it = q.pop_front();
                check(chan === it.exp, it.tag, int'(chan), int'(it.exp));
            end
        end
    end

    task automatic model_tick();
        if (m_blank) return;
        for (int c = 0; c < NCH; c++) m_out[c] = !m_done && (m_cnt < m_gs[c]);
        if (!m_done) begin
            if (m_cnt == MAXV) begin
                if (m_rpt) m_cnt = 0;
                else       m_done = 1;
            end else m_cnt++;
        end
    endtask

    task automatic do_latch(int sel, int r, int g, int b,
        bit blank, bit rpt, bit rst, bit ext, bit rise);
        @(negedge clk);
        word  = mk_word(sel, r, g, b, blank, rpt, rst, ext, rise);
        latch = 1'b1;
        @(negedge clk);
        latch = 1'b0;
        for (int c = 0; c < NCH; c++) m_gs[c] = gs_of(sel, c);
        m_blank = blank; m_rpt = rpt; m_ext = ext; m_rise = rise;
        if (rst || blank) begin m_cnt = 0; m_done = 0; m_out = '0; end
        repeat (2) @(negedge clk);
    endtask

    task automatic ref_edge(bit ext, bit rise, string tag);
        @(negedge clk);
        if (ext) ser = rise; else osc = rise;
        if (ext == m_ext && rise == m_rise) model_tick();
        repeat (HALF - 1) @(negedge clk);
        push(tag);
    endtask

    task automatic ref_cycles(bit ext, int n, string tag);
        for (int i = 0; i < n; i++) begin
            ref_edge(ext, 1'b1, tag);
            ref_edge(ext, 1'b0, tag);
        end
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int c = 0; c < NCH; c++) m_gs[c] = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: reset state, blank holds outputs off
        check(chan == '0, "R1 outputs after reset", int'(chan), 0);
        check(br_r == 0 && br_g == 0 && br_b == 0, "R1 brightness after reset",
              int'({br_r, br_g, br_b}), 0);
        ref_cycles(1'b0, 3, "R1 osc toggling under blank");
        ref_cycles(1'b1, 3, "R1 ser toggling under blank");

        // R2: word without latch has no effect
        @(negedge clk);
        word = mk_word(0, 5, 9, 100, 0, 1, 0, 0, 1);
        repeat (3) @(negedge clk);
        check(br_r == 0 && br_b == 0, "R2 no load without latch", int'(br_b), 0);
        ref_cycles(1'b0, 2, "R2 still blank without latch");

        // R2/R4: latch releases blank, brightness fields land
        do_latch(0, 5, 9, 100, 0, 1, 0, 0, 1);
        check(br_r == 5,   "R2 red brightness", int'(br_r), 5);
        check(br_g == 9,   "R2 green brightness", int'(br_g), 9);
        check(br_b == 100, "R2 blue brightness", int'(br_b), 100);

        // R3/R5/R9: two full repeat periods on rising osc edges
        ref_cycles(1'b0, 2 * (MAXV + 1) + 3, "R3 R5 R9 repeat compare");
        // R8: serial clock ignored while osc selected
        ref_cycles(1'b1, 4, "R8 serial ignored");

        // R7: latch without restart keeps count, new values take effect
        do_latch(1, 5, 9, 100, 0, 1, 0, 0, 1);
        push("R7 no-restart latch keeps outputs");
        ref_cycles(1'b0, 10, "R7 count continues after latch");

        // R7: restart latch, one-shot, serial clock, falling edge
        do_latch(0, 1, 2, 3, 0, 0, 1, 1, 0);
        push("R7 restart forces off");
        ref_cycles(1'b0, 4, "R8 osc ignored on serial select");
        ref_cycles(1'b1, (MAXV + 1) + 6, "R6 R9 one-shot falling edge");
        check(chan == '0, "R6 outputs stay off after one period", int'(chan), 0);

        // R6/R7: restart latch starts another single period
        do_latch(0, 1, 2, 3, 0, 0, 1, 1, 0);
        ref_cycles(1'b1, 5, "R6 new period after restart");

        // R4: blank forces off, release counts from zero
        do_latch(0, 1, 2, 3, 1, 1, 0, 0, 1);
        push("R4 blank forces off");
        ref_cycles(1'b0, 5, "R4 held while blank");
        do_latch(0, 1, 2, 3, 0, 1, 0, 0, 1);
        ref_cycles(1'b0, 6, "R4 count restarts after release");

        repeat (4) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule